// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block decides which probe samples an embedded logic analyzer keeps. Once a capture is started, the probe bundle is written once per clock into a circular sample store of `SAMPLE_DEPTH` entries. Which cycles are written depends on the capture mode. In single-shot mode, a pre-trigger count places the trigger cycle inside the kept window. In incremental mode, only the cycles with the trigger input high are kept. In immediate mode, the store is filled at once.

A host on a register bus picks the mode and the pre-trigger count, then sends a one-cycle start pulse. It polls the state code until the capture has finished. It then reads the store through a registered read port. The controller reports the physical slot of the oldest kept sample, so the host can read the samples in time order.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle). The controller stays idle, whatever the trigger input does, until a start pulse arrives.
- R2: State codes are: 0 idle, 1 pre-fill, 2 armed, 3 capturing, 4 done. A start in single-shot mode with pre-trigger count L>0 gives exactly L pre-fill cycles and then the armed state. With L=0 the controller goes straight to armed.
- R3: A trigger input that is high during pre-fill is ignored. The controller continues to pre-fill and then arms.
- R4: In single-shot mode (mode code 0), with L below the depth, the kept window is: the L samples before the first trigger seen while armed, the sample of the trigger cycle itself, and the samples that follow it, for `SAMPLE_DEPTH` samples in total. The state reads done exactly `SAMPLE_DEPTH`-L cycles after the trigger cycle.
- R5: When L equals the depth, the window is the `SAMPLE_DEPTH` samples that precede the trigger cycle, and the state reads done one cycle after it. A pre-trigger count above the depth behaves exactly like one equal to the depth.
- R6: In incremental mode (mode code 1), the pre-trigger count is ignored and the state goes straight to capturing. A sample is stored only in cycles where the trigger input is high, until `SAMPLE_DEPTH` samples are stored.
- R7: In immediate mode (mode code 2), the controller stores the `SAMPLE_DEPTH` samples of the cycles right after the start cycle, without regard to the trigger.
- R8: When done, `rd_base_o` gives the slot of the oldest sample, and slot (`rd_base_o`+i) mod `SAMPLE_DEPTH` holds the i-th oldest sample. Read data appears one clock after the address.
- R9: A start pulse while pre-filling, armed or capturing has no effect on the state or the stored window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle capture start request |
| mode_i | input | 2 | Capture mode: 0 single-shot, 1 incremental, 2 immediate |
| trig_loc_i | input | clog2(SAMPLE_DEPTH)+1 | Pre-trigger sample count, latched at start |
| trig_i | input | 1 | Trigger condition from the trigger logic |
| probe_i | input | PROBE_W | Probe bundle sampled every clock |
| rd_addr_i | input | clog2(SAMPLE_DEPTH) | Physical read slot |
| state_o | output | 3 | Controller state code |
| rd_base_o | output | clog2(SAMPLE_DEPTH) | Slot of the oldest kept sample |
| rd_data_o | output | PROBE_W | Registered read data |

## Verification
The hardest case to reach is the join between the pre-trigger and post-trigger parts of the window. It is most delicate when the pre-trigger count equals or exceeds the depth, because then the trigger cycle itself must not be stored. The bench drives a running cycle stamp on the probes, so each stored word names the cycle it came from. It holds the trigger back until it sees the armed code, and it also raises a stray trigger during pre-fill. The expected window and the oldest-slot index then follow from the stamp of the trigger cycle alone.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ARMED = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_e;

  typedef enum logic [1:0] {
    MODE_SHOT = 2'd0,
    MODE_INCR = 2'd1,
    MODE_IMM  = 2'd2,
    MODE_RSVD = 2'd3
  } cap_mode_e;

endpackage

// File: rtl/la_rst_sync.sv
module la_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW:0]   loc_i,
  input  logic          trig_i,
  output cap_state_e    state_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_ptr_o
);

  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    state_q, state_d;
  cap_mode_e     mode_q, mode_d;
  logic [AW:0]   loc_q, loc_d, cnt_q, cnt_d, cnt_inc, loc_clamped;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          wr_en, arm, cnt_en;

  assign loc_clamped = (loc_i > FULL) ? FULL : loc_i;
  assign cnt_inc     = cnt_q + (AW+1)'(1);
  assign arm         = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  // next-state and write decision
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    loc_d   = loc_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          mode_d = cap_mode_e'(mode_i);
          loc_d  = loc_clamped;
          cnt_d  = '0;
          if ((mode_d == MODE_INCR) || (mode_d == MODE_IMM)) state_d = ST_CAPT;
          else if (loc_clamped == '0)                        state_d = ST_ARMED;
          else                                               state_d = ST_PRE;
        end
      end
      ST_PRE: begin
        wr_en = 1'b1;
        cnt_d = cnt_inc;
        if (cnt_inc == loc_q) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (trig_i) begin
          if (cnt_q == FULL) begin
            state_d = ST_DONE;
          end else begin
            wr_en   = 1'b1;
            cnt_d   = cnt_inc;
            state_d = (cnt_inc == FULL) ? ST_DONE : ST_CAPT;
          end
        end else begin
          wr_en = 1'b1;
        end
      end
      ST_CAPT: begin
        if ((mode_q != MODE_INCR) || trig_i) begin
          wr_en = 1'b1;
          cnt_d = cnt_inc;
          if (cnt_inc == FULL) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (arm)        ptr_d = '0;
    else if (wr_en) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
    else            ptr_d = ptr_q;
  end

  assign cnt_en = arm || wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SHOT;
      loc_q  <= '0;
    end else if (arm) begin
      mode_q <= mode_d;
      loc_q  <= loc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
    end
  end

  assign state_o  = state_q;
  assign wr_en_o  = wr_en;
  assign wr_ptr_o = ptr_q;

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int PROBE_W      = 8,
  parameter int SAMPLE_DEPTH = 16,
  localparam int AW          = $clog2(SAMPLE_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [AW:0]        trig_loc_i,
  input  logic               trig_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [2:0]         state_o,
  output logic [AW-1:0]      rd_base_o,
  output logic [PROBE_W-1:0] rd_data_o
);

  logic          rst_n_s;
  cap_state_e    state;
  logic          wr_en;
  logic [AW-1:0] wr_ptr;

  la_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  la_cap_fsm #(
    .DEPTH (SAMPLE_DEPTH),
    .AW    (AW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .loc_i    (trig_loc_i),
    .trig_i   (trig_i),
    .state_o  (state),
    .wr_en_o  (wr_en),
    .wr_ptr_o (wr_ptr)
  );

  la_sample_ram #(
    .W     (PROBE_W),
    .DEPTH (SAMPLE_DEPTH),
    .AW    (AW)
  ) u_ram (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (probe_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign state_o   = state;
  assign rd_base_o = wr_ptr;

endmodule

// File: rtl/la_capture_ctrl_chk.sv
module la_capture_ctrl_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          trig_i,
  input logic [2:0]    state_o,
  input logic [AW-1:0] rd_base_o
);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !start_i) |=> (state_o == 3'd0));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  // R3
  prefill_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |=> (state_o == 3'd1 || state_o == 3'd2));

  // R4
  armed_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && trig_i) |=> (state_o == 3'd3 || state_o == 3'd4));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !start_i) |=> (state_o == 3'd4));

  // R8
  base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !start_i) |=> $stable(rd_base_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && start_i) |=> (state_o == 3'd3 || state_o == 3'd4));

endmodule

bind la_capture_ctrl la_capture_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .trig_i    (trig_i),
  .state_o   (state_o),
  .rd_base_o (rd_base_o)
);

// File: tb/la_capture_ctrl_test.sv
module la_capture_ctrl_test;

  localparam int DEPTH = 16;
  localparam int PW    = 16;
  localparam int AW    = 4;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [1:0]    mode_i;
  logic [AW:0]   trig_loc_i;
  logic          trig_i;
  logic [PW-1:0] probe_i;
  logic [AW-1:0] rd_addr_i;
  logic [2:0]    state_o;
  logic [AW-1:0] rd_base_o;
  logic [PW-1:0] rd_data_o;

  int checks = 0;
  int fails  = 0;
  int stamp  = 0;
  int s0;
  int tr;
  logic rd_req = 1'b0;
  logic pend   = 1'b0;
  int    expq[$];
  string tagq[$];
  int    expv[$];

  la_capture_ctrl #(.PROBE_W(PW), .SAMPLE_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .trig_loc_i(trig_loc_i), .trig_i(trig_i), .probe_i(probe_i),
    .rd_addr_i(rd_addr_i), .state_o(state_o), .rd_base_o(rd_base_o),
    .rd_data_o(rd_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic s);
    @(negedge clk);
    stamp++;
    probe_i = PW'(stamp);
    trig_i  = t;
    start_i = s;
  endtask

  task automatic begin_cap(input int m, input int l);
    mode_i     = 2'(m);
    trig_loc_i = (AW+1)'(l);
    step(1'b0, 1'b1);
    s0 = stamp;
  endtask

  task automatic wait_done(input string req, input int exp_steps);
    int n = 0;
    while (state_o != 3'd4 && n < 64) begin
      step(1'b0, 1'b0);
      n++;
    end
    chk(req, n, exp_steps);
  endtask

  // driver: pushes expected words and issues reads in time order
  task automatic readout(input string req, input int base);
    chk({req, " oldest slot"}, int'(rd_base_o), base);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      expq.push_back(expv[i]);
      tagq.push_back(req);
      rd_addr_i = AW'((base + i) % DEPTH);
      rd_req    = 1'b1;
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill_run(input int first);
    expv.delete();
    for (int i = 0; i < DEPTH; i++) expv.push_back(first + i);
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) pend <= rd_req;

  always @(negedge clk) begin
    if (pend) begin
      int e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (int'(rd_data_o) != (e & 16'hFFFF)) begin
        fails++;
        $display("FAIL %s read data actual=%0d expected=%0d", t, rd_data_o, e);
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; trig_loc_i = '0;
    trig_i = 1'b0; probe_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0);
    chk("R1 reset state", int'(state_o), 0);
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R1 idle ignores trigger", int'(state_o), 0);

    // single-shot, pre-trigger 5, stray trigger during pre-fill
    begin_cap(0, 5);
    for (int i = 1; i <= 5; i++) begin
      step(i == 3, 1'b0);
      chk((i >= 4) ? "R3 pre-fill continues" : "R2 pre-fill", int'(state_o), 1);
    end
    step(1'b0, 1'b0);
    chk("R2 armed after pre-fill", int'(state_o), 2);
    repeat (3) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    tr = stamp;
    wait_done("R4 done delay", DEPTH - 5);
    fill_run(tr - 5);
    readout("R4 window L=5", (tr - 5 - s0 - 1) % DEPTH);

    // single-shot, pre-trigger 0
    begin_cap(0, 0);
    step(1'b0, 1'b0);
    chk("R2 armed at once", int'(state_o), 2);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    tr = stamp;
    wait_done("R4 done delay L=0", DEPTH);
    fill_run(tr);
    readout("R4 window L=0", (tr - s0 - 1) % DEPTH);

    // single-shot, pre-trigger equal to depth
    begin_cap(0, DEPTH);
    for (int i = 1; i <= DEPTH; i++) step(1'b0, 1'b0);
    chk("R5 pre-fill last", int'(state_o), 1);
    step(1'b0, 1'b0);
    chk("R5 armed", int'(state_o), 2);
    repeat (2) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    tr = stamp;
    wait_done("R5 done delay", 1);
    fill_run(tr - DEPTH);
    readout("R5 window L=depth", (tr - DEPTH - s0 - 1) % DEPTH);

    // single-shot, pre-trigger above depth
    begin_cap(0, DEPTH + 5);
    for (int i = 1; i <= DEPTH; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R5 clamped pre-fill", int'(state_o), 2);
    step(1'b1, 1'b0);
    tr = stamp;
    wait_done("R5 clamped done delay", 1);
    fill_run(tr - DEPTH);
    readout("R5 window clamped", (tr - DEPTH - s0 - 1) % DEPTH);

    // incremental
    begin_cap(1, 5);
    expv.delete();
    for (int i = 1; i < 200 && expv.size() < DEPTH; i++) begin
      step((i % 3) == 0, 1'b0);
      if (i == 1) chk("R6 capturing at once", int'(state_o), 3);
      if ((i % 3) == 0) expv.push_back(stamp);
    end
    chk("R6 capturing before last", int'(state_o), 3);
    step(1'b0, 1'b0);
    chk("R6 done", int'(state_o), 4);
    readout("R6 window", 0);

    // immediate, with start pulse mid-capture
    begin_cap(2, 9);
    for (int i = 1; i <= DEPTH; i++) begin
      step(1'b0, i == 5);
      if (i == 6) chk("R9 start ignored", int'(state_o), 3);
    end
    chk("R7 capturing last", int'(state_o), 3);
    step(1'b0, 1'b0);
    chk("R7 done", int'(state_o), 4);
    fill_run(s0 + 1);
    readout("R7 window", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule